// File: doc/BRIEF.md
# Gated Duplicate Concurrent Error Checker

This block computes a small combinational function on a stream of input words. A second copy of the same function runs beside the main copy, and a comparator sets an error flag when the two results disagree. The duplicate copy does not run on every word. A linear feedback shift register, together with a programmable mask, decides for each accepted word whether that word is checked. On words that are not checked, the input register of the duplicate keeps its old value, so the duplicate logic does not toggle, and no error can be raised. Changing the mask at run time therefore trades detection coverage against switching power.

In online-test mode the duplicate receives a separate test word instead of the data word. Its result is then compared with an expected value that arrives with the beat, and the main result is not part of the comparison. Test-mode beats are always checked. A fault-injection mask XORs into the duplicate's result, so the detection path can be exercised from the outside.

Data moves through valid/ready handshakes. There is one result register stage. A new beat is accepted whenever that stage is empty or is being drained in the same cycle. While a result is waiting and `out_ready` is low, `in_ready` is low and every result field holds its value.

Top module: `dupchk_top`

## Requirements
- R1: `out_data` for an accepted beat with input x equals rotate-left-by-one(x) XOR (x + K) modulo 2^W, where K defaults to 8'h5A and W defaults to 8.
- R2: `in_ready` equals `!out_valid || out_ready`. A beat is accepted on a clock edge where `in_valid && in_ready` holds. Its result appears with `out_valid` high after that edge, and `out_valid` falls after an edge where `out_ready` is high and no beat is accepted.
- R3: While `out_valid` is high and `out_ready` is low, `out_data`, `out_err` and `out_chk` hold their values and no new beat is accepted.
- R4: A normal-mode beat is checked (`out_chk`=1) exactly when the bitwise AND of the generator state and `cfg_mask` is nonzero at acceptance. The state advances once per accepted beat as next = {s[L-2:0], XOR-reduce(s & TAPS)}, with TAPS = 16'hB400. The state after reset is 16'hACE1.
- R5: With `cfg_mask` all zero, no normal-mode beat is checked.
- R6: For an unchecked beat, the duplicate's input register keeps its previous value and `out_err` is 0, whatever `in_inj` is.
- R7: For a checked normal-mode beat, `out_err` is 1 exactly when the duplicate result XOR `in_inj` differs from the main result.
- R8: When `in_test` is 1, the duplicate is given `in_tvec` and the beat is always checked. `out_err` is 1 exactly when the duplicate result XOR `in_inj` differs from `in_texp`. `out_data` still follows R1 on `in_data`.
- R9: A cycle with `cfg_load` high sets the generator state to `cfg_seed`, or to 1 when `cfg_seed` is zero. A load takes priority over the per-beat advance, and the state is never zero.
- R10: After reset, `out_valid`, `out_err` and `out_chk` are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take a beat |
| in_data | input | W | Data word for the main copy |
| in_test | input | 1 | Online-test beat |
| in_tvec | input | W | Test word for the duplicate in test mode |
| in_texp | input | W | Expected duplicate result in test mode |
| in_inj | input | W | Fault mask XORed into the duplicate result |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | W | Main copy result |
| out_err | output | 1 | Mismatch on a checked beat |
| out_chk | output | 1 | This result was checked |
| cfg_load | input | 1 | Load the generator seed |
| cfg_seed | input | L | Seed value |
| cfg_mask | input | L | Condition mask |

## Verification
The assertions assume that `cfg_mask` and `in_test` are stable during the cycle in which a beat is accepted, and that `cfg_load` is not pulsed while a beat is held under back-pressure. The bench changes the mask and the seed only on negative edges between beats. It drives every input half a cycle away from the sampling edge, and it releases `out_ready` only after it has checked that the held result is stable.

// File: rtl/dupchk_pkg.sv
package dupchk_pkg;
  typedef enum logic {MODE_NORMAL = 1'b0, MODE_TEST = 1'b1} chk_mode_e;

  localparam int unsigned DEF_W    = 8;
  localparam int unsigned DEF_L    = 16;
  localparam logic [15:0] DEF_TAPS = 16'hB400;
  localparam logic [15:0] DEF_RST  = 16'hACE1;
endpackage

// File: rtl/dupchk_func.sv
module dupchk_func #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] K = 8'h5A
) (
  input  logic [W-1:0] x,
  output logic [W-1:0] y
);
  logic [W-1:0] rot;
  logic [W-1:0] sum;

  // rotate left by one, then mix with an offset sum
  generate
    if (W == 1) begin : g_rot1
      assign rot = x;
    end else begin : g_rotn
      assign rot = {x[W-2:0], x[W-1]};
    end
  endgenerate

  assign sum = x + K;
  assign y   = rot ^ sum;
endmodule

// File: rtl/dupchk_lfsr.sv
module dupchk_lfsr #(
  parameter int unsigned L = 16,
  parameter logic [L-1:0] TAPS = 16'hB400,
  parameter logic [L-1:0] RST_SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [L-1:0] seed,
  input  logic         step,
  input  logic [L-1:0] mask,
  output logic         cond,
  output logic [L-1:0] state
);
  localparam logic [L-1:0] NZ_FILL = {{(L-1){1'b0}}, 1'b1};

  logic [L-1:0] st_q;
  logic [L-1:0] st_next;
  logic         fb;
  logic [L-1:0] seed_fix;

  assign fb       = ^(st_q & TAPS);
  assign seed_fix = (seed == '0) ? NZ_FILL : seed;

  generate
    if (L == 1) begin : g_l1
      assign st_next = st_q;
    end else begin : g_ln
      assign st_next = {st_q[L-2:0], fb};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= (RST_SEED == '0) ? NZ_FILL : RST_SEED;
    end else if (load) begin
      st_q <= seed_fix;
    end else if (step) begin
      st_q <= st_next;
    end
  end

  assign cond  = |(st_q & mask);
  assign state = st_q;
endmodule

// File: rtl/dupchk_cmp.sv
module dupchk_cmp #(
  parameter int unsigned W = 8
) (
  input  logic                   vld,
  input  logic                   chk,
  input  dupchk_pkg::chk_mode_e  mode,
  input  logic [W-1:0]           main_y,
  input  logic [W-1:0]           dup_y,
  input  logic [W-1:0]           exp_y,
  output logic                   err
);
  logic [W-1:0] ref_y;
  logic         diff;

  always_comb begin
    ref_y = (mode == dupchk_pkg::MODE_TEST) ? exp_y : main_y;
    diff  = (ref_y != dup_y);
    err   = vld && chk && diff;
  end
endmodule

// File: rtl/dupchk_top.sv
module dupchk_top #(
  parameter int unsigned W = dupchk_pkg::DEF_W,
  parameter int unsigned L = dupchk_pkg::DEF_L,
  parameter logic [W-1:0] K = 8'h5A,
  parameter logic [L-1:0] TAPS = dupchk_pkg::DEF_TAPS,
  parameter logic [L-1:0] RST_SEED = dupchk_pkg::DEF_RST
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic         in_test,
  input  logic [W-1:0] in_tvec,
  input  logic [W-1:0] in_texp,
  input  logic [W-1:0] in_inj,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic         out_err,
  output logic         out_chk,
  input  logic         cfg_load,
  input  logic [L-1:0] cfg_seed,
  input  logic [L-1:0] cfg_mask
);
  import dupchk_pkg::*;

  logic         acc;
  logic         cond;
  logic         active;
  logic [L-1:0] lfsr_st;

  logic [W-1:0] main_q;
  logic [W-1:0] dup_in_q;
  logic [W-1:0] exp_q;
  logic [W-1:0] inj_q;
  chk_mode_e    mode_q;
  logic         chk_q;
  logic         vld_q;

  logic [W-1:0] main_y;
  logic [W-1:0] dup_raw;
  logic [W-1:0] dup_y;

  assign in_ready = !vld_q || out_ready;
  assign acc      = in_valid && in_ready;
  assign active   = in_test || cond;

  dupchk_lfsr #(.L(L), .TAPS(TAPS), .RST_SEED(RST_SEED)) u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (cfg_load),
    .seed  (cfg_seed),
    .step  (acc),
    .mask  (cfg_mask),
    .cond  (cond),
    .state (lfsr_st)
  );

  // result stage: loads on every accepted beat
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      main_q <= '0;
      exp_q  <= '0;
      inj_q  <= '0;
      mode_q <= MODE_NORMAL;
      chk_q  <= 1'b0;
      vld_q  <= 1'b0;
    end else if (acc) begin
      main_q <= in_data;
      exp_q  <= in_texp;
      inj_q  <= in_inj;
      mode_q <= in_test ? MODE_TEST : MODE_NORMAL;
      chk_q  <= active;
      vld_q  <= 1'b1;
    end else if (out_ready) begin
      vld_q  <= 1'b0;
    end
  end

  // duplicate operand register: frozen unless the beat is checked
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dup_in_q <= '0;
    end else if (acc && active) begin
      dup_in_q <= in_test ? in_tvec : in_data;
    end
  end

  dupchk_func #(.W(W), .K(K)) u_main (.x(main_q),   .y(main_y));
  dupchk_func #(.W(W), .K(K)) u_dup  (.x(dup_in_q), .y(dup_raw));

  assign dup_y = dup_raw ^ inj_q;

  dupchk_cmp #(.W(W)) u_cmp (
    .vld    (vld_q),
    .chk    (chk_q),
    .mode   (mode_q),
    .main_y (main_y),
    .dup_y  (dup_y),
    .exp_y  (exp_q),
    .err    (out_err)
  );

  assign out_valid = vld_q;
  assign out_data  = main_y;
  assign out_chk   = vld_q && chk_q;
endmodule

// File: rtl/dupchk_sva.sv
module dupchk_sva #(
  parameter int unsigned W = 8,
  parameter int unsigned L = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         in_test,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_data,
  input logic         out_err,
  input logic         out_chk,
  input logic         cfg_load,
  input logic [L-1:0] cfg_mask,
  input logic [W-1:0] dup_in_q,
  input logic [L-1:0] lfsr_st
);
  assert_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == (!out_valid || out_ready));

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !cfg_load) |=>
      (out_valid && $stable(out_data) && $stable(out_err) && $stable(out_chk)));

  assert_mask_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_test && cfg_mask == '0) |=> !out_chk);

  assert_dup_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_test && (lfsr_st & cfg_mask) == '0)
      |=> $stable(dup_in_q));

  assert_err_chk_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> (out_chk && out_valid));

  assert_test_chk_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_test) |=> out_chk);

  assert_lfsr_nz_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_st != '0);
endmodule

bind dupchk_top dupchk_sva #(.W(W), .L(L)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_test   (in_test),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_err   (out_err),
  .out_chk   (out_chk),
  .cfg_load  (cfg_load),
  .cfg_mask  (cfg_mask),
  .dup_in_q  (dup_in_q),
  .lfsr_st   (lfsr_st)
);

// File: tb/dupchk_tb.sv
module dupchk_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;

  // {data, test, tvec, exp_good, inj}
  typedef struct packed {
    logic [7:0] d;
    logic       t;
    logic [7:0] tv;
    logic       good;
    logic [7:0] inj;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{8'h00, 1'b0, 8'h00, 1'b1, 8'h00},
    '{8'hFF, 1'b0, 8'h00, 1'b1, 8'h01},
    '{8'h3C, 1'b1, 8'h81, 1'b1, 8'h00},
    '{8'hA5, 1'b1, 8'h10, 1'b0, 8'h00},
    '{8'h7E, 1'b0, 8'h00, 1'b1, 8'h80},
    '{8'h11, 1'b0, 8'h00, 1'b1, 8'h00},
    '{8'hC3, 1'b1, 8'hC3, 1'b1, 8'h04},
    '{8'h5A, 1'b0, 8'h00, 1'b1, 8'h00}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic        in_test = 1'b0;
  logic [7:0]  in_tvec = '0;
  logic [7:0]  in_texp = '0;
  logic [7:0]  in_inj = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [7:0]  out_data;
  logic        out_err;
  logic        out_chk;
  logic        cfg_load = 1'b0;
  logic [15:0] cfg_seed = '0;
  logic [15:0] cfg_mask = 16'hFFFF;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] ms = 16'hACE1;
  logic [7:0]  mdup = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  dupchk_top dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_test(in_test), .in_tvec(in_tvec), .in_texp(in_texp),
    .in_inj(in_inj), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_err(out_err), .out_chk(out_chk),
    .cfg_load(cfg_load), .cfg_seed(cfg_seed), .cfg_mask(cfg_mask)
  );

  function automatic logic [7:0] fref(input logic [7:0] x);
    logic [7:0] r;
    r = (x << 1) | (x >> 7);
    return r ^ (x + 8'h5A);
  endfunction

  function automatic logic [15:0] step_ref(input logic [15:0] s);
    return {s[14:0], ^(s & 16'hB400)};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one accepted beat, results checked on the following negedge
  task automatic beat(input logic [7:0] d, input logic t, input logic [7:0] tv,
                      input logic [7:0] te, input logic [7:0] inj);
    logic act;
    logic [7:0] dy;
    logic e;
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_test = t; in_tvec = tv; in_texp = te; in_inj = inj;
    act = t || ((ms & cfg_mask) != 16'h0);
    ms = step_ref(ms);
    if (act) mdup = t ? tv : d;
    dy = fref(mdup) ^ inj;
    e = act && (t ? (dy != te) : (dy != fref(d)));
    @(posedge clk);
    @(negedge clk);
    check("R2 out_valid", {15'h0, out_valid}, 16'h1);
    check("R1/R8 out_data", {8'h0, out_data}, {8'h0, fref(d)});
    check("R4/R5/R8 out_chk", {15'h0, out_chk}, {15'h0, act});
    check("R6/R7/R8 out_err", {15'h0, out_err}, {15'h0, e});
    in_valid = 1'b0;
  endtask

  task automatic load_seed(input logic [15:0] s);
    @(negedge clk);
    cfg_load = 1'b1; cfg_seed = s;
    @(posedge clk);
    @(negedge clk);
    cfg_load = 1'b0;
    ms = (s == 16'h0) ? 16'h0001 : s;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    check("R10 out_valid", {15'h0, out_valid}, 16'h0);
    check("R10 out_err", {15'h0, out_err}, 16'h0);
    check("R10 out_chk", {15'h0, out_chk}, 16'h0);
    check("R10 in_ready", {15'h0, in_ready}, 16'h1);
    rst_n = 1'b1;

    // table walk: full mask, then sparse mask (R4, R6, R7, R8)
    for (int pass = 0; pass < 2; pass++) begin
      cfg_mask = (pass == 0) ? 16'hFFFF : 16'h0003;
      for (int i = 0; i < NVEC; i++) begin
        beat(VECS[i].d, VECS[i].t, VECS[i].tv,
             VECS[i].good ? fref(VECS[i].tv) : ~fref(VECS[i].tv), VECS[i].inj);
      end
    end

    // R5: zero mask never checks normal beats, even with faults injected
    cfg_mask = 16'h0000;
    for (int i = 0; i < 4; i++) beat(8'h20 + 8'(i), 1'b0, 8'h00, 8'h00, 8'hFF);
    // R8: test beat is still checked under zero mask
    beat(8'h44, 1'b1, 8'h09, fref(8'h09), 8'h00);

    // R9: zero seed replaced by 1; with mask 1 first beat checked, second not
    cfg_mask = 16'h0001;
    load_seed(16'h0000);
    beat(8'h01, 1'b0, 8'h00, 8'h00, 8'h00);
    beat(8'h02, 1'b0, 8'h00, 8'h00, 8'h02);
    load_seed(16'h8001);
    beat(8'h03, 1'b0, 8'h00, 8'h00, 8'h10);

    // R3: back-pressure holds result and blocks the next beat
    cfg_mask = 16'hFFFF;
    @(negedge clk);
    out_ready = 1'b0;
    beat(8'h66, 1'b0, 8'h00, 8'h00, 8'h08);
    held = out_data;
    @(negedge clk);
    in_valid = 1'b1; in_data = 8'h99; in_test = 1'b0; in_inj = 8'h00;
    @(posedge clk);
    @(negedge clk);
    check("R3 in_ready low", {15'h0, in_ready}, 16'h0);
    check("R3 out_data held", {8'h0, out_data}, {8'h0, held});
    check("R3 out_err held", {15'h0, out_err}, 16'h1);
    check("R3 out_valid held", {15'h0, out_valid}, 16'h1);
    out_ready = 1'b1;
    @(posedge clk);
    ms = step_ref(ms);
    mdup = 8'h99;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2 held beat taken", {8'h0, out_data}, {8'h0, fref(8'h99)});
    check("R2 no error", {15'h0, out_err}, 16'h0);
    @(posedge clk);
    @(negedge clk);
    check("R2 out_valid drops", {15'h0, out_valid}, 16'h0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule